// File: doc/BRIEF.md
# Audio Master Clock Divider

This block derives an audio master clock from the kernel clock it runs on. A 4-bit divide field selects an even ratio of twice its value. A field of zero selects ratio 1. A separate bypass bit forces ratio 1 whatever the field holds. Because the block is written for a single clock domain, it does not drive a real gated clock. It produces a registered square-wave level `mclk_o`, a one-cycle strobe `mclk_stb_o` that marks each rising edge of that level, and `mclk_valid_o`, which qualifies both. Downstream logic uses the strobe as a clock enable.

The divide settings are captured into shadow registers on every cycle in which the audio block is disabled, and are frozen while it is enabled. The divider runs only when the audio block is both enabled and master. When the block is a slave, the outputs are held low and carry no meaning. Each time the divider starts, the phase counter restarts from zero, so the first period has full length.

Top module: `amc_mclk_div`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it, `mclk_o`, `mclk_stb_o` and `mclk_valid_o` are 0. The shadowed settings reset to field 0 with bypass 0, which is ratio 1.
- R2: `mclk_valid_o` rises one cycle after `enable_i && master_i` is first sampled high at a clock edge. It falls one cycle after that term is sampled low. Whenever `mclk_valid_o` is 0, `mclk_o` and `mclk_stb_o` are also 0.
- R3: With a captured field of 0 and bypass 0, `mclk_o` and `mclk_stb_o` are both 1 on every cycle after the first valid cycle.
- R4: With a captured field N from 1 to 15 and bypass 0, `mclk_o` has period 2N with N cycles high and N cycles low. Counting the first valid cycle as t=0, `mclk_o` equals ((t / N) mod 2).
- R5: `mclk_stb_o` is high for exactly one cycle at each 0-to-1 transition of `mclk_o` in divide mode, that is at t mod 2N == N, and is low otherwise.
- R6: With bypass 1, the output follows ratio 1 (as in R3) for every field value.
- R7: `div_i` and `bypass_i` are captured only on cycles where `enable_i` is 0. Changes while `enable_i` is 1 leave the output waveform unchanged.
- R8: With `master_i` at 0, all three outputs stay 0 whatever `enable_i` and the settings are.
- R9: Each disable followed by a re-enable restarts the phase, so the waveform after every restart matches R3/R4 counted from its own t=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Audio block enable; settings load while low |
| master_i | input | 1 | 1 when the audio block is clock master |
| div_i | input | 4 | Divide field; ratio is 2×value, 0 means ratio 1 |
| bypass_i | input | 1 | Forces ratio 1, overriding the field |
| mclk_o | output | 1 | Registered divided clock level |
| mclk_stb_o | output | 1 | One-cycle strobe on each rising edge of the divided clock |
| mclk_valid_o | output | 1 | Qualifies the divided clock and strobe |

## Verification
The bench sweeps all 32 combinations of bypass and field and predicts every sampled cycle arithmetically from t. A counter compare that is off by one would stretch or shorten the half periods. A missing bypass term would divide when it should pass through. A strobe tied to the wrong edge would fire on the falling transition. The bench rewrites the settings while the block is enabled, and a shadow register that kept loading would then switch ratio in mid-stream. It also holds enable high through reset to expose a wrong reset ratio, and runs with master low to catch a divider that is not gated by slave mode.

// File: rtl/amc_pkg.sv
package amc_pkg;
  parameter int DIV_W = 4;

  typedef struct packed {
    logic             bypass;
    logic [DIV_W-1:0] div;
  } amc_cfg_t;
endpackage

// File: rtl/amc_cfg_latch.sv
module amc_cfg_latch
  import amc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     load_i,
  input  amc_cfg_t cfg_i,
  output amc_cfg_t cfg_o
);
  amc_cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
    end else if (load_i) begin
      cfg_q <= cfg_i;
    end
  end

  assign cfg_o = cfg_q;

  // R7
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(load_i) |-> $stable(cfg_q));
endmodule

// File: rtl/amc_ratio_decode.sv
module amc_ratio_decode
  import amc_pkg::*;
(
  input  amc_cfg_t         cfg_i,
  output logic             ratio1_o,
  output logic [DIV_W-1:0] last_o
);
  always_comb begin
    ratio1_o = cfg_i.bypass || (cfg_i.div == '0);
    last_o   = cfg_i.div - 1'b1;
  end
endmodule

// File: rtl/amc_phase_gen.sv
module amc_phase_gen
  import amc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             ratio1_i,
  input  logic [DIV_W-1:0] last_i,
  output logic             mclk_o,
  output logic             stb_o,
  output logic             valid_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mclk_q;
  logic             stb_q;
  logic             valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q   <= '0;
      mclk_q  <= 1'b0;
      stb_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      valid_q <= 1'b1;
    end else if (ratio1_i) begin
      cnt_q  <= '0;
      mclk_q <= 1'b1;
      stb_q  <= 1'b1;
    end else if (cnt_q == last_i) begin
      cnt_q  <= '0;
      mclk_q <= ~mclk_q;
      stb_q  <= ~mclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      stb_q <= 1'b0;
    end
  end

  assign mclk_o  = mclk_q;
  assign stb_o   = stb_q;
  assign valid_o = valid_q;

  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_q |-> (!mclk_q && !stb_q));

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !valid_q);

  // R5
  stb_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_q && !mclk_q) |-> 1'b0 == 1'b1 ? 1'b0 : !stb_q);

  // R5
  stb_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && valid_q && !ratio1_i && $rose(stb_q)) |-> $rose(mclk_q));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && valid_q && !ratio1_i) |-> (cnt_q <= last_i));
endmodule

// File: rtl/amc_mclk_div.sv
module amc_mclk_div
  import amc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             enable_i,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bypass_i,
  output logic             mclk_o,
  output logic             mclk_stb_o,
  output logic             mclk_valid_o
);
  amc_cfg_t         cfg_in;
  amc_cfg_t         cfg_cur;
  logic             ratio1;
  logic [DIV_W-1:0] last;
  logic             run;

  assign cfg_in.bypass = bypass_i;
  assign cfg_in.div    = div_i;
  assign run           = enable_i && master_i;

  amc_cfg_latch u_cfg (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (!enable_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_cur)
  );

  amc_ratio_decode u_dec (
    .cfg_i    (cfg_cur),
    .ratio1_o (ratio1),
    .last_o   (last)
  );

  amc_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (run),
    .ratio1_i (ratio1),
    .last_i   (last),
    .mclk_o   (mclk_o),
    .stb_o    (mclk_stb_o),
    .valid_o  (mclk_valid_o)
  );

  // R8
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(master_i) |-> (!mclk_valid_o && !mclk_o && !mclk_stb_o));
endmodule

// File: tb/amc_mclk_div_tb.sv
`timescale 1ns/1ps
module amc_mclk_div_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic       master;
  logic [3:0] div;
  logic       bypass;
  logic       mclk;
  logic       stb;
  logic       valid;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  amc_mclk_div u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .enable_i     (enable),
    .master_i     (master),
    .div_i        (div),
    .bypass_i     (bypass),
    .mclk_o       (mclk),
    .mclk_stb_o   (stb),
    .mclk_valid_o (valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Compares one sampled cycle against the arithmetic model for ratio
  // 1 (n == 0) or ratio 2n.
  task automatic expect_at(input string req, input int n, input int t);
    logic em;
    logic es;
    if (n == 0) begin
      em = (t >= 1);
      es = (t >= 1);
    end else begin
      em = ((t / n) % 2) == 1;
      es = (t % (2 * n)) == n;
    end
    chk(req, valid, 1'b1);
    chk(req, mclk, em);
    chk({req, " stb R5"}, stb, es);
  endtask

  task automatic start_cfg(input logic b, input logic [3:0] d);
    @(negedge clk);
    enable = 1'b0;
    master = 1'b1;
    bypass = b;
    div    = d;
    @(negedge clk);
    @(negedge clk);
    chk("R2 idle valid", valid, 1'b0);
    chk("R2 idle mclk", mclk, 1'b0);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst    = 1'b1;
    enable = 1'b1;
    master = 1'b1;
    div    = 4'd7;
    bypass = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mclk", mclk, 1'b0);
    chk("R1 stb", stb, 1'b0);
    chk("R1 valid", valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    // R1: shadow reset to ratio 1, enable held so field 7 never loads
    for (int t = 0; t < 12; t++) begin
      expect_at("R1 reset ratio", 0, t);
      @(negedge clk);
    end

    // R3 R4 R6 R9: sweep all settings
    for (int b = 0; b < 2; b++) begin
      for (int d = 0; d < 16; d++) begin
        int n;
        n = (b == 1) ? 0 : d;
        start_cfg(b[0], d[3:0]);
        for (int t = 0; t < ((n == 0) ? 8 : 6 * n); t++) begin
          if (b == 1) expect_at("R6 bypass", n, t);
          else if (d == 0) expect_at("R3 ratio1", n, t);
          else expect_at("R4 divide", n, t);
          @(negedge clk);
        end
      end
    end

    // R7: settings change while enabled has no effect
    start_cfg(1'b0, 4'd3);
    for (int t = 0; t < 40; t++) begin
      if (t == 2) begin
        div    = 4'd5;
        bypass = 1'b1;
      end
      expect_at("R7 frozen", 3, t);
      @(negedge clk);
    end

    // R2: disable drops valid on the next cycle
    enable = 1'b0;
    @(negedge clk);
    chk("R2 fall valid", valid, 1'b0);
    chk("R2 fall mclk", mclk, 1'b0);
    chk("R2 fall stb", stb, 1'b0);

    // R8: slave mode keeps outputs low
    div    = 4'd1;
    bypass = 1'b0;
    @(negedge clk);
    master = 1'b0;
    enable = 1'b1;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk("R8 slave valid", valid, 1'b0);
      chk("R8 slave mclk", mclk, 1'b0);
      chk("R8 slave stb", stb, 1'b0);
    end
    // R2 R9: becoming master restarts with the frozen field 1
    master = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 8; t++) begin
      expect_at("R9 restart", 1, t);
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule